// File: doc/BRIEF.md
# Bus I/O Port Adapter

This block joins an 8-bit peripheral with a ninth parity bit to a backplane bus that has separate output and input data groups. It responds to the bus as a pair of I/O ports, not as memory. The upper seven bits of the eight-bit port address are compared with a seven-bit base value set by switches. The lowest address bit goes straight to the peripheral as its register select. A cycle is taken only when exactly one of the two I/O status lines (input or output) is active and the address matches.

On an output cycle, the adapter drives the peripheral's write bus from the bus output lines and produces a write strobe while the bus write pulse is high. On an input cycle, the adapter gives a read strobe to the peripheral while the bus read-enable is high. During that window it drives the peripheral's nine bits onto the bus input lines and raises their drive enable. Outside that window the input lines are released.

The block is purely combinational, so it has no clock and no reset. Data moves in single bus transfers that the bus strobes pace, so there is no valid/ready handshake and no back-pressure: the peripheral must keep up with each strobe. The ninth bit carries odd parity. A parameter picks whether that bit is taken from bus output bit 8 or generated from the low byte.

Top module: `bus_io_port_adapter`

## Requirements
- R1: `per_cs` is high exactly when `bus_addr[7:1]` equals `base_sw` and exactly one of `bus_stat_in` and `bus_stat_out` is high.
- R2: When both status lines are high, or both are low (a memory cycle), `per_cs`, `per_wr`, `per_rd`, `bus_din_oe` and `per_wdata_oe` all stay low, whatever the address and strobes are.
- R3: `per_rs` always equals `bus_addr[0]`.
- R4: `per_wr` is high exactly when `per_cs`, `bus_stat_out` and `bus_wr_pulse` are all high. `bus_rd_enable` has no effect on it.
- R5: `per_rd` is high exactly when `per_cs`, `bus_stat_in` and `bus_rd_enable` are all high. `bus_wr_pulse` has no effect on it.
- R6: `bus_din_oe` equals `per_rd`. While it is high, `bus_din` equals all nine bits of `per_rdata`, parity bit 8 included. While it is low, `bus_din` is all zeros.
- R7: `per_wdata_oe` is high exactly when `per_cs` and `bus_stat_out` are both high. While it is high, `per_wdata[7:0]` equals `bus_dout[7:0]`. While it is low, `per_wdata` is all zeros.
- R8: With `USE_BUS_PARITY`=1 (the default), `per_wdata[8]` equals `bus_dout[8]` during an output drive.
- R9: With `USE_BUS_PARITY`=0, `per_wdata[8]` during an output drive is set so that the nine written bits hold an odd number of ones. `bus_dout[8]` is ignored.
- R10: `per_wr` and `per_rd` are never high together. `bus_din_oe` and `per_wdata_oe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_sw | input | 7 | Base address switches, compared with address bits 7..1 |
| bus_addr | input | 8 | Bus port address |
| bus_stat_in | input | 1 | Bus status: I/O input cycle |
| bus_stat_out | input | 1 | Bus status: I/O output cycle |
| bus_wr_pulse | input | 1 | Bus write pulse |
| bus_rd_enable | input | 1 | Bus data-in enable (read window) |
| bus_dout | input | 9 | Bus output data lines; bit 8 is parity |
| bus_din | output | 9 | Bus input data lines; bit 8 is parity |
| bus_din_oe | output | 1 | Drive enable for bus_din |
| per_cs | output | 1 | Peripheral chip select |
| per_rs | output | 1 | Peripheral register select |
| per_wr | output | 1 | Peripheral write strobe |
| per_rd | output | 1 | Peripheral read strobe |
| per_wdata | output | 9 | Data toward the peripheral |
| per_wdata_oe | output | 1 | Drive enable for per_wdata |
| per_rdata | input | 9 | Data from the peripheral |

## Verification
The block has no state, so a fault in the decode or the steering shows at the ports during the same bus cycle as the stimulus. A decode error appears as a chip select or strobe on a foreign port, or during a memory cycle, or during a cycle with both status lines set. A steering error appears as both data drivers enabled at once, as data leaking onto the input lines outside the read window, or as a wrong ninth bit. Random cycles with a biased address hit rate are mixed with directed cases: neighbouring addresses, contradictory status, and the all-zero and all-one parity bytes. Both parity variants are checked.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

  // Bus cycle classes derived from the two I/O status lines.
  typedef enum logic [1:0] {
    CYC_NONE = 2'b00,
    CYC_IN   = 2'b01,
    CYC_OUT  = 2'b10,
    CYC_BAD  = 2'b11
  } cyc_kind_t;

endpackage

// File: rtl/bpa_decode.sv
module bpa_decode
  import bpa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 1,
  localparam int BASE_W = ADDR_W - SEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic              stat_in,
  input  logic              stat_out,
  output logic              hit,
  output cyc_kind_t         kind,
  output logic [SEL_W-1:0]  sel
);

  // The upper address field selects the port group; the low field is passed on.
  assign hit = (addr[ADDR_W-1:SEL_W] == base);
  assign sel = addr[SEL_W-1:0];

  always_comb begin
    unique case ({stat_out, stat_in})
      2'b01:   kind = CYC_IN;
      2'b10:   kind = CYC_OUT;
      2'b11:   kind = CYC_BAD;
      default: kind = CYC_NONE;
    endcase
  end

endmodule

// File: rtl/bpa_strobe.sv
module bpa_strobe
  import bpa_pkg::*;
(
  input  logic      hit,
  input  cyc_kind_t kind,
  input  logic      wr_pulse,
  input  logic      rd_enable,
  output logic      cs,
  output logic      wr,
  output logic      rd,
  output logic      wr_drive,
  output logic      rd_drive
);

  logic is_in;
  logic is_out;

  assign is_in    = (kind == CYC_IN);
  assign is_out   = (kind == CYC_OUT);
  assign cs       = hit && (is_in || is_out);
  assign wr_drive = hit && is_out;
  assign rd_drive = hit && is_in && rd_enable;
  assign wr       = wr_drive && wr_pulse;
  assign rd       = rd_drive;

  // R10: the strobes are mutually exclusive.
  always_comb begin
    if (!$isunknown({wr, rd}))
      a_r10_strobes_exclusive: assert (!(wr && rd));
  end

  // R4: a write strobe only happens inside a selected cycle.
  always_comb begin
    if (!$isunknown({wr, cs}))
      a_r4_wr_inside_cs: assert (!wr || cs);
  end

endmodule

// File: rtl/bpa_steer.sv
module bpa_steer #(
  parameter int DATA_W         = 8,
  parameter bit USE_BUS_PARITY = 1'b1,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              wr_drive,
  input  logic              rd_drive,
  input  logic [WORD_W-1:0] bus_dout,
  input  logic [WORD_W-1:0] per_rdata,
  output logic [WORD_W-1:0] per_wdata,
  output logic [WORD_W-1:0] bus_din
);

  logic par_bit;

  generate
    if (USE_BUS_PARITY) begin : g_bus_par
      assign par_bit = bus_dout[DATA_W];
    end else begin : g_gen_par
      // Odd parity: the ninth bit makes the total count of ones odd.
      assign par_bit = ~(^bus_dout[DATA_W-1:0]);
    end
  endgenerate

  assign per_wdata = wr_drive ? {par_bit, bus_dout[DATA_W-1:0]} : '0;
  assign bus_din   = rd_drive ? per_rdata : '0;

  // R6: the input lines carry nothing outside the read window.
  always_comb begin
    if (!$isunknown({rd_drive, bus_din}))
      a_r6_din_quiet: assert (rd_drive || (bus_din == '0));
  end

  // R9: a generated write word always holds an odd number of ones.
  always_comb begin
    if (!USE_BUS_PARITY && wr_drive && !$isunknown(per_wdata))
      a_r9_odd_word: assert (^per_wdata == 1'b1);
  end

endmodule

// File: rtl/bus_io_port_adapter.sv
module bus_io_port_adapter
  import bpa_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int SEL_W          = 1,
  parameter int DATA_W         = 8,
  parameter bit USE_BUS_PARITY = 1'b1
) (
  input  logic [ADDR_W-SEL_W-1:0] base_sw,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_stat_in,
  input  logic                    bus_stat_out,
  input  logic                    bus_wr_pulse,
  input  logic                    bus_rd_enable,
  input  logic [DATA_W:0]         bus_dout,
  output logic [DATA_W:0]         bus_din,
  output logic                    bus_din_oe,
  output logic                    per_cs,
  output logic [SEL_W-1:0]        per_rs,
  output logic                    per_wr,
  output logic                    per_rd,
  output logic [DATA_W:0]         per_wdata,
  output logic                    per_wdata_oe,
  input  logic [DATA_W:0]         per_rdata
);

  logic      hit;
  cyc_kind_t kind;
  logic      rd_drive;
  logic      wr_drive;

  bpa_decode #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
  ) u_decode (
    .addr     (bus_addr),
    .base     (base_sw),
    .stat_in  (bus_stat_in),
    .stat_out (bus_stat_out),
    .hit      (hit),
    .kind     (kind),
    .sel      (per_rs)
  );

  bpa_strobe u_strobe (
    .hit       (hit),
    .kind      (kind),
    .wr_pulse  (bus_wr_pulse),
    .rd_enable (bus_rd_enable),
    .cs        (per_cs),
    .wr        (per_wr),
    .rd        (per_rd),
    .wr_drive  (wr_drive),
    .rd_drive  (rd_drive)
  );

  bpa_steer #(
    .DATA_W         (DATA_W),
    .USE_BUS_PARITY (USE_BUS_PARITY)
  ) u_steer (
    .wr_drive  (wr_drive),
    .rd_drive  (rd_drive),
    .bus_dout  (bus_dout),
    .per_rdata (per_rdata),
    .per_wdata (per_wdata),
    .bus_din   (bus_din)
  );

  assign bus_din_oe   = rd_drive;
  assign per_wdata_oe = wr_drive;

  // R10: the two data drivers are never on together.
  always_comb begin
    if (!$isunknown({bus_din_oe, per_wdata_oe}))
      a_r10_drivers_exclusive: assert (!(bus_din_oe && per_wdata_oe));
  end

  // R2: contradictory status never selects the peripheral.
  always_comb begin
    if (!$isunknown({bus_stat_in, bus_stat_out, per_cs}))
      a_r2_bad_cycle_idle: assert (!(bus_stat_in && bus_stat_out) || !per_cs);
  end

  // R5: the read strobe needs an input status and the read window.
  always_comb begin
    if (!$isunknown({per_rd, bus_stat_in, bus_rd_enable}))
      a_r5_rd_qualified: assert (!per_rd || (bus_stat_in && bus_rd_enable));
  end

endmodule

// File: tb/bus_io_port_adapter_test.sv
module bus_io_port_adapter_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [6:0] base_sw;
  logic [7:0] bus_addr;
  logic       bus_stat_in, bus_stat_out, bus_wr_pulse, bus_rd_enable;
  logic [8:0] bus_dout, per_rdata;
  logic [8:0] bus_din, per_wdata, g_bus_din, g_per_wdata;
  logic       bus_din_oe, per_cs, per_wr, per_rd, per_wdata_oe;
  logic       g_bus_din_oe, g_per_cs, g_per_wr, g_per_rd, g_per_wdata_oe;
  logic [0:0] per_rs, g_per_rs;

  bus_io_port_adapter uut (
    .base_sw(base_sw), .bus_addr(bus_addr), .bus_stat_in(bus_stat_in),
    .bus_stat_out(bus_stat_out), .bus_wr_pulse(bus_wr_pulse),
    .bus_rd_enable(bus_rd_enable), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_din_oe(bus_din_oe), .per_cs(per_cs), .per_rs(per_rs), .per_wr(per_wr),
    .per_rd(per_rd), .per_wdata(per_wdata), .per_wdata_oe(per_wdata_oe),
    .per_rdata(per_rdata)
  );

  bus_io_port_adapter #(.USE_BUS_PARITY(1'b0)) uut_gen (
    .base_sw(base_sw), .bus_addr(bus_addr), .bus_stat_in(bus_stat_in),
    .bus_stat_out(bus_stat_out), .bus_wr_pulse(bus_wr_pulse),
    .bus_rd_enable(bus_rd_enable), .bus_dout(bus_dout), .bus_din(g_bus_din),
    .bus_din_oe(g_bus_din_oe), .per_cs(g_per_cs), .per_rs(g_per_rs), .per_wr(g_per_wr),
    .per_rd(g_per_rd), .per_wdata(g_per_wdata), .per_wdata_oe(g_per_wdata_oe),
    .per_rdata(per_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_cs(input logic [7:0] a, input logic [6:0] b, input logic si, input logic so);
    return (a[7:1] == b) && (si != so);
  endfunction

  function automatic logic odd_bit(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    return (n % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic drive(input logic [7:0] a, input logic si, input logic so, input logic wp,
                       input logic re, input logic [8:0] d, input logic [8:0] r);
    @(negedge clk);
    bus_addr = a; bus_stat_in = si; bus_stat_out = so; bus_wr_pulse = wp;
    bus_rd_enable = re; bus_dout = d; per_rdata = r;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all();
    bit cs, wr, rd, wdoe;
    logic [8:0] ewd, ewg, edi;
    cs   = exp_cs(bus_addr, base_sw, bus_stat_in, bus_stat_out);
    wr   = cs && bus_stat_out && bus_wr_pulse;
    rd   = cs && bus_stat_in && bus_rd_enable;
    wdoe = cs && bus_stat_out;
    edi  = rd ? per_rdata : 9'h0;
    ewd  = wdoe ? bus_dout : 9'h0;
    ewg  = wdoe ? {odd_bit(bus_dout[7:0]), bus_dout[7:0]} : 9'h0;
    chk(per_cs == cs,             "R1 cs", 16'(per_cs), 16'(cs));
    chk(per_rs[0] == bus_addr[0], "R3 rs", 16'(per_rs), 16'(bus_addr[0]));
    chk(per_wr == wr,             "R4 wr", 16'(per_wr), 16'(wr));
    chk(per_rd == rd,             "R5 rd", 16'(per_rd), 16'(rd));
    chk(bus_din_oe == rd && bus_din == edi, "R6 din", 16'({bus_din_oe, bus_din}), 16'({rd, edi}));
    chk(per_wdata_oe == wdoe && per_wdata[7:0] == ewd[7:0], "R7 wdata",
        16'({per_wdata_oe, per_wdata[7:0]}), 16'({wdoe, ewd[7:0]}));
    chk(per_wdata[8] == ewd[8],   "R8 bus parity", 16'(per_wdata[8]), 16'(ewd[8]));
    chk(g_per_wdata == ewg,       "R9 gen parity", 16'(g_per_wdata), 16'(ewg));
    chk(!(per_wr && per_rd) && !(bus_din_oe && per_wdata_oe), "R10 exclusive",
        16'({per_wr, per_rd, bus_din_oe, per_wdata_oe}), 16'h0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    base_sw = 7'h2A;
    // idle bus state
    drive(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 9'h000);
    chk(!per_cs && !bus_din_oe && !per_wdata_oe, "R2 idle", 16'({per_cs, bus_din_oe, per_wdata_oe}), 16'h0);
    check_all();
    // R2: memory cycle at matching address with both strobes high
    drive(8'h55, 1'b0, 1'b0, 1'b1, 1'b1, 9'h1A5, 9'h0FF);
    chk(!per_cs && !per_wr && !per_rd && !bus_din_oe && !per_wdata_oe, "R2 memory cycle",
        16'({per_cs, per_wr, per_rd, bus_din_oe, per_wdata_oe}), 16'h0);
    // R2: both status lines set
    drive(8'h54, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0C3, 9'h1FF);
    chk(!per_cs && !per_wr && !per_rd && !bus_din_oe && !per_wdata_oe, "R2 both status",
        16'({per_cs, per_wr, per_rd, bus_din_oe, per_wdata_oe}), 16'h0);
    // R1: neighbouring ports do not select
    drive(8'h56, 1'b1, 1'b0, 1'b0, 1'b1, 9'h000, 9'h133);
    chk(!per_cs && !bus_din_oe, "R1 neighbour up", 16'({per_cs, bus_din_oe}), 16'h0);
    drive(8'h53, 1'b0, 1'b1, 1'b1, 1'b0, 9'h011, 9'h000);
    chk(!per_cs && !per_wr, "R1 neighbour down", 16'({per_cs, per_wr}), 16'h0);
    // R6: read with parity bit, R3 select high
    drive(8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 9'h000, 9'h1A7);
    chk(bus_din == 9'h1A7 && bus_din_oe, "R6 read word", 16'(bus_din), 16'h1A7);
    chk(per_rs[0] == 1'b1, "R3 select", 16'(per_rs), 16'h1);
    check_all();
    // R5: input cycle, read window closed
    drive(8'h54, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0FF, 9'h1FF);
    chk(!per_rd && !bus_din_oe && bus_din == 9'h0, "R5 window closed", 16'({per_rd, bus_din}), 16'h0);
    // R9 parity corners
    drive(8'h54, 1'b0, 1'b1, 1'b1, 1'b0, 9'h000, 9'h000);
    chk(g_per_wdata == 9'h100, "R9 zero byte", 16'(g_per_wdata), 16'h100);
    drive(8'h54, 1'b0, 1'b1, 1'b1, 1'b0, 9'h1FF, 9'h000);
    chk(g_per_wdata == 9'h1FF, "R9 ones byte", 16'(g_per_wdata), 16'h1FF);
    chk(per_wdata == 9'h1FF, "R8 pass bit", 16'(per_wdata), 16'h1FF);
    drive(8'h54, 1'b0, 1'b1, 1'b0, 1'b0, 9'h101, 9'h000);
    chk(g_per_wdata == 9'h001, "R9 single one", 16'(g_per_wdata), 16'h001);
    chk(per_wdata == 9'h101 && per_wdata_oe && !per_wr, "R7 drive without pulse",
        16'({per_wr, per_wdata}), 16'h101);
    // random phase across three base settings
    for (int ph = 0; ph < 3; ph++) begin
      base_sw = 7'($urandom);
      for (int i = 0; i < 400; i++) begin
        logic [7:0] a;
        a = ($urandom % 2) ? {base_sw, 1'($urandom)} : 8'($urandom);
        drive(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              9'($urandom), 9'($urandom));
        check_all();
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule